// File: doc/BRIEF.md
# I2C Master Command Sequencer

This block is a master-only I2C bus engine. Software controls it through one 8-bit control register of single-shot command bits. Setting one bit makes the engine produce a Start, a Repeated Start, a Stop, one received byte, or an acknowledge slot on the open-drain SDA and SCL lines. The engine clears the bit by itself when that sequence is complete. Writing the data buffer while the engine is idle sends one byte and then samples the slave's acknowledge.

The engine never drives a line high. Each line has an enable output, and while the enable is set the line is pulled low. Each SCL half-period lasts `divisor + 1` system clocks. A one-cycle completion pulse marks the end of every sequence. While a sequence is running, new command bits and buffer writes are dropped, not queued. This keeps the register contents and the bus waveform matched to a single operation.

Top module: `i2c_cmd_master`

## Requirements
- R1: After reset the control register reads 0x00, both line enables are 0 (lines released) and the completion pulse is low.
- R2: Control bit 0 (start) written while idle releases SDA and SCL for one half-period, then pulls SDA low with SCL still released, then pulls SCL low.
- R3: Control bit 1 (repeated start) written while idle, with SCL held low, releases SDA, then releases SCL, then pulls SDA low, then pulls SCL low. Each of these steps lasts one half-period.
- R4: Control bit 2 (stop) written while idle pulls SDA low with SCL low, then releases SCL, then releases SDA, and leaves both lines released.
- R5: A buffer write while idle sends the byte MSB first, with one low and one high half-period per bit, followed by a 9th clock with SDA released and then a final low half-period. Control bit 6 (acknowledge status) is captured at the end of the 9th high half: 0 if SDA was low, 1 if SDA was high.
- R6: Control bit 3 (receive) written while idle gives eight clocks with SDA released, followed by a final low half-period. SDA is sampled at the end of each high half, MSB first, and the resulting byte is shown on the buffer read port.
- R7: Control bit 4 (acknowledge sequence) written while idle gives one clock that drives control bit 5 (acknowledge data), followed by a final low half with SDA released. An acknowledge-data value of 0 pulls SDA low, and a value of 1 leaves SDA released. A value of bit 5 written in the same write is the one that is used.
- R8: While a sequence runs, writes of command bits and buffer writes have no effect on the lines, on the command bits read back, or on the running sequence.
- R9: Each half-period lasts exactly divisor + 1 system clocks.
- R10: When any sequence completes, the completion output is high for exactly one clock, and in that same clock the command bit reads back as 0. The lines keep their final state until the next sequence starts.
- R11: During byte and acknowledge clocks, SDA changes only while SCL is held low.
- R12: If a write sets more than one command bit, only the lowest-numbered one is accepted.
- R13: Control bit 6 is read-only, and writing it does not change its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register read value |
| buf_wr | input | 1 | Transmit buffer write strobe |
| buf_wdata | input | DATA_W | Byte to transmit |
| buf_rdata | output | DATA_W | Last received byte |
| divisor | input | DIV_W | Half-period length minus one, in clocks |
| done_irq | output | 1 | One-cycle completion pulse |
| sda_in | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
The assertions assume that the divisor does not change while a sequence runs and that it is at least 1, so that the synchronised SDA sample falls inside a stable high half. They also assume that the slave changes SDA only while SCL is held low. The stimulus sets the divisor only between operations and uses the values 2, 4 and 7. The modelled slave sets its bit when each low half-period begins and holds it through the following high half.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;
   localparam int NUM_CMDS  = 5;
   localparam int BIT_ACKD  = 5;
   localparam int BIT_ACKST = 6;
   typedef enum logic [2:0] {
      OP_START  = 3'd0,
      OP_RSTART = 3'd1,
      OP_STOP   = 3'd2,
      OP_RX     = 3'd3,
      OP_ACK    = 3'd4,
      OP_TX     = 3'd5
   } op_e;
endpackage

// File: rtl/i2c_cmd_regs.sv
module i2c_cmd_regs
   import i2c_cmd_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ctl_wr,
   input  logic [7:0] ctl_wdata,
   input  logic       buf_wr,
   input  logic       busy,
   input  logic       finish,
   input  logic       ack_stat,
   output logic       go,
   output op_e        go_op,
   output logic       ack_data,
   output logic [7:0] ctl_rdata
);
   logic [NUM_CMDS-1:0] cmd_q, req, pick;
   logic                ackd_q, cmd_go;

   assign req    = ctl_wr ? ctl_wdata[NUM_CMDS-1:0] : '0;
   assign pick   = req & (~req + 1'b1);
   assign cmd_go = !busy && (|req);
   assign go     = cmd_go || (!busy && buf_wr);
   assign ack_data  = ctl_wr ? ctl_wdata[BIT_ACKD] : ackd_q;
   assign ctl_rdata = {1'b0, ack_stat, ackd_q, cmd_q};

   always_comb begin
      go_op = OP_TX;
      for (int i = NUM_CMDS - 1; i >= 0; i--)
         if (req[i]) go_op = op_e'(i[2:0]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q  <= '0;
         ackd_q <= 1'b0;
      end else begin
         if (finish)      cmd_q <= '0;
         else if (cmd_go) cmd_q <= pick;
         if (ctl_wr)      ackd_q <= ctl_wdata[BIT_ACKD];
      end
   end

   AST_CMD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cmd_q)); // R12
   AST_CMD_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !finish) |=> $stable(cmd_q)); // R8
   AST_CMD_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      finish |=> (cmd_q == '0)); // R10
endmodule

// File: rtl/i2c_cmd_timer.sv
module i2c_cmd_timer #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [DIV_W-1:0] divisor,
   output logic             expire
);
   logic [DIV_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (load)         cnt_q <= divisor;
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   assign expire = (cnt_q == '0);

   AST_TIMER_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (load && divisor != '0) |=> !expire); // R9
endmodule

// File: rtl/i2c_cmd_seq.sv
module i2c_cmd_seq
   import i2c_cmd_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  op_e               go_op,
   input  logic              ack_data,
   input  logic [DATA_W-1:0] tx_byte,
   input  logic              expire,
   input  logic              sda_in,
   output logic              load,
   output logic              busy,
   output logic              finish,
   output logic              done,
   output logic              scl_oe,
   output logic              sda_oe,
   output logic [DATA_W-1:0] rx_byte,
   output logic              ack_stat
);
   localparam int NSTEP  = 2 * DATA_W + 3;
   localparam int STEP_W = $clog2(NSTEP + 1);

   op_e               op_q;
   logic [STEP_W-1:0] step_q;
   logic [DATA_W-1:0] tx_q;
   logic              ackd_q, sda_s, last, smp;
   logic [2:0]        nxt;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign sda_s = sda_in;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sync_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '1;
            else        sync_q <= {sync_q[SYNC_STAGES-2+(SYNC_STAGES==1):0], sda_in};
         end
         assign sda_s = sync_q[SYNC_STAGES-1];
      end
   endgenerate

   function automatic logic [STEP_W-1:0] last_step(input op_e op);
      case (op)
         OP_RSTART: return STEP_W'(3);
         OP_RX:     return STEP_W'(2 * DATA_W);
         OP_TX:     return STEP_W'(2 * DATA_W + 2);
         default:   return STEP_W'(2);
      endcase
   endfunction

   // {scl_low, sda_low, sample}
   function automatic logic [2:0] pattern(input op_e op, input logic [STEP_W-1:0] s,
                                          input logic [DATA_W-1:0] tb, input logic ad);
      logic b;
      b = tb[DATA_W - 1 - int'(s >> 1)];
      case (op)
         OP_START:  return (s == 0) ? 3'b000 : (s == 1) ? 3'b010 : 3'b110;
         OP_RSTART: return (s == 0) ? 3'b100 : (s == 1) ? 3'b000 : (s == 2) ? 3'b010 : 3'b110;
         OP_STOP:   return (s == 0) ? 3'b110 : (s == 1) ? 3'b010 : 3'b000;
         OP_ACK:    return (s == 2) ? 3'b100 : {!s[0], !ad, 1'b0};
         OP_RX:     return (int'(s) < 2 * DATA_W) ? {!s[0], 1'b0, s[0]} : 3'b100;
         default: begin
            if (int'(s) < 2 * DATA_W)       return {!s[0], !b, 1'b0};
            else if (int'(s) == 2 * DATA_W + 1) return 3'b001;
            else                            return 3'b100;
         end
      endcase
   endfunction

   assign last   = busy && expire && (step_q == last_step(op_q));
   assign finish = last;
   assign load   = go || (busy && expire && !last);
   assign smp    = pattern(op_q, step_q, tx_q, ackd_q)[0];
   assign nxt    = go ? pattern(go_op, '0, tx_byte, ack_data)
                      : pattern(op_q, step_q + 1'b1, tx_q, ackd_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0; op_q <= OP_START; step_q <= '0; tx_q <= '0;
         ackd_q <= 1'b0; rx_byte <= '0; ack_stat <= 1'b0; done <= 1'b0;
         scl_oe <= 1'b0; sda_oe <= 1'b0;
      end else begin
         done <= finish;
         if (go) begin
            busy   <= 1'b1;
            op_q   <= go_op;
            step_q <= '0;
            tx_q   <= tx_byte;
            ackd_q <= ack_data;
            {scl_oe, sda_oe} <= nxt[2:1];
         end else if (busy && expire) begin
            if (smp && op_q == OP_RX) rx_byte  <= {rx_byte[DATA_W-2+(DATA_W==1):0], sda_s};
            if (smp && op_q == OP_TX) ack_stat <= sda_s;
            if (last) busy <= 1'b0;
            else begin
               step_q <= step_q + 1'b1;
               {scl_oe, sda_oe} <= nxt[2:1];
            end
         end
      end
   end

   AST_SDA_ONLY_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(sda_oe) && !scl_oe && !$past(scl_oe))
         |-> (op_q inside {OP_START, OP_RSTART, OP_STOP})); // R11
   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R10
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !go) |=> ($stable(scl_oe) && $stable(sda_oe))); // R10
   AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      (finish && op_q == OP_STOP) |=> (!scl_oe && !sda_oe)); // R4
endmodule

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master
   import i2c_cmd_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int DIV_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_wr,
   input  logic [7:0]        ctl_wdata,
   output logic [7:0]        ctl_rdata,
   input  logic              buf_wr,
   input  logic [DATA_W-1:0] buf_wdata,
   output logic [DATA_W-1:0] buf_rdata,
   input  logic [DIV_W-1:0]  divisor,
   output logic              done_irq,
   input  logic              sda_in,
   output logic              scl_oe,
   output logic              sda_oe
);
   generate
      if (DATA_W < 1)                         begin : g_bad_data $error("DATA_W must be at least 1"); end
      if (DIV_W < 2)                          begin : g_bad_div  $error("DIV_W must be at least 2"); end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 3) begin : g_bad_sync $error("SYNC_STAGES must be 0..3"); end
   endgenerate

   logic go, load, expire, busy, finish, ack_data, ack_stat;
   op_e  go_op;

   i2c_cmd_regs u_regs (
      .clk, .rst_n, .ctl_wr, .ctl_wdata, .buf_wr, .busy, .finish, .ack_stat,
      .go, .go_op, .ack_data, .ctl_rdata
   );

   i2c_cmd_timer #(.DIV_W(DIV_W)) u_timer (
      .clk, .rst_n, .load, .divisor, .expire
   );

   i2c_cmd_seq #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_seq (
      .clk, .rst_n, .go, .go_op, .ack_data, .tx_byte(buf_wdata), .expire, .sda_in,
      .load, .busy, .finish, .done(done_irq), .scl_oe, .sda_oe,
      .rx_byte(buf_rdata), .ack_stat
   );
endmodule

// File: tb/test_i2c_cmd_master.sv
module test_i2c_cmd_master;
   typedef struct packed {
      logic       scl;
      logic       sda;
      logic       done;
      logic [4:0] cmd;
      logic       slv;
   } ent_t;

   logic       clk = 1'b0, rst_n = 1'b0;
   logic       ctl_wr = 1'b0, buf_wr = 1'b0;
   logic [7:0] ctl_wdata = '0, ctl_rdata, buf_wdata = '0, buf_rdata;
   logic [7:0] divisor = 8'd4;
   logic       done_irq, scl_oe, sda_oe, sda_in;
   logic       slave_sda = 1'b1, started = 1'b0, hold_scl = 1'b0, hold_sda = 1'b0;
   logic       model_ackd = 1'b0;
   int         n_tests = 0, n_fail = 0;
   string      cur_req = "R1";
   ent_t       exp_q[$];

   always #4 clk = ~clk;
   assign sda_in = sda_oe ? 1'b0 : slave_sda;

   i2c_cmd_master i_i2c_cmd_master (
      .clk, .rst_n, .ctl_wr, .ctl_wdata, .ctl_rdata, .buf_wr, .buf_wdata, .buf_rdata,
      .divisor, .done_irq, .sda_in, .scl_oe, .sda_oe
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      ent_t e;
      if (exp_q.size() > 0) e = exp_q.pop_front();
      else e = '{scl: hold_scl, sda: hold_sda, done: 1'b0, cmd: 5'd0, slv: 1'b1};
      hold_scl  = e.scl;
      hold_sda  = e.sda;
      slave_sda = e.slv;
      if (started)
         check(cur_req, {8'd0, scl_oe, sda_oe, done_irq, ctl_rdata[4:0]},
               {8'd0, e.scl, e.sda, e.done, e.cmd});
   end

   // Expected per-cycle line states for one operation: op 0..4 = command bit, 5 = byte send
   function automatic void plan(input int op, input logic [7:0] b, input logic ad,
                                input logic [7:0] sb, input logic sack);
      logic [2:0] st[$];
      logic [4:0] cmd;
      cmd = (op < 5) ? 5'(1 << op) : 5'd0;
      case (op)
         0: st = '{3'b001, 3'b011, 3'b111};
         1: st = '{3'b101, 3'b001, 3'b011, 3'b111};
         2: st = '{3'b111, 3'b011, 3'b001};
         3: begin
            for (int i = 7; i >= 0; i--) begin
               st.push_back({2'b10, sb[i]});
               st.push_back({2'b00, sb[i]});
            end
            st.push_back(3'b101);
         end
         4: st = '{{1'b1, !ad, 1'b1}, {1'b0, !ad, 1'b1}, 3'b101};
         default: begin
            for (int i = 7; i >= 0; i--) begin
               st.push_back({1'b1, !b[i], 1'b1});
               st.push_back({1'b0, !b[i], 1'b1});
            end
            st.push_back({2'b10, sack});
            st.push_back({2'b00, sack});
            st.push_back(3'b101);
         end
      endcase
      foreach (st[k])
         for (int c = 0; c <= int'(divisor); c++)
            exp_q.push_back('{scl: st[k][2], sda: st[k][1], done: 1'b0, cmd: cmd, slv: st[k][0]});
      exp_q.push_back('{scl: st[st.size()-1][2], sda: st[st.size()-1][1], done: 1'b1,
                        cmd: 5'd0, slv: 1'b1});
   endfunction

   task automatic wait_idle();
      while (exp_q.size() > 0) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic ctl_write(input logic [7:0] d, input int op, input logic [7:0] sb, input logic sack);
      @(negedge clk);
      ctl_wr = 1'b1; ctl_wdata = d;
      @(posedge clk); #1;
      ctl_wr = 1'b0;
      model_ackd = d[5];
      if (exp_q.size() == 0 && op >= 0) plan(op, 8'h00, d[5], sb, sack);
   endtask

   task automatic buf_write(input logic [7:0] b, input logic sack, input logic expect_go);
      @(negedge clk);
      buf_wr = 1'b1; buf_wdata = b;
      @(posedge clk); #1;
      buf_wr = 1'b0;
      if (expect_go && exp_q.size() == 0) plan(5, b, 1'b0, 8'h00, sack);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", {8'd0, ctl_rdata}, 16'h0000);
      check("R1", {13'd0, scl_oe, sda_oe, done_irq}, 16'h0000);
      started = 1'b1;

      cur_req = "R2";  ctl_write(8'h01, 0, 8'h00, 1'b1); wait_idle();
      cur_req = "R5";  buf_write(8'hA5, 1'b0, 1'b1);    wait_idle();
      check("R5", {15'd0, ctl_rdata[6]}, 16'd0);
      buf_write(8'h3C, 1'b1, 1'b1); wait_idle();
      check("R5", {15'd0, ctl_rdata[6]}, 16'd1);
      cur_req = "R3";  ctl_write(8'h02, 1, 8'h00, 1'b1); wait_idle();
      cur_req = "R6";  ctl_write(8'h08, 3, 8'hC9, 1'b1); wait_idle();
      check("R6", {8'd0, buf_rdata}, 16'h00C9);
      cur_req = "R7";  ctl_write(8'h10, 4, 8'h00, 1'b1); wait_idle();
      cur_req = "R6";  ctl_write(8'h08, 3, 8'h5E, 1'b1); wait_idle();
      check("R6", {8'd0, buf_rdata}, 16'h005E);
      cur_req = "R7";  ctl_write(8'h30, 4, 8'h00, 1'b1); wait_idle();
      check("R7", {15'd0, ctl_rdata[5]}, 16'd1);

      // R8: writes while a receive runs are dropped
      cur_req = "R8";  ctl_write(8'h08, 3, 8'h81, 1'b1);
      repeat (10) @(negedge clk);
      ctl_write(8'h05, -1, 8'h00, 1'b1);
      buf_write(8'hFF, 1'b0, 1'b0);
      wait_idle();
      check("R8", {8'd0, buf_rdata}, 16'h0081);
      check("R8", {15'd0, ctl_rdata[6]}, 16'd1);

      cur_req = "R12"; ctl_write(8'h0C, 2, 8'h00, 1'b1); wait_idle();
      check("R12", {14'd0, scl_oe, sda_oe}, 16'd0);

      cur_req = "R9";  divisor = 8'd2;
      ctl_write(8'h01, 0, 8'h00, 1'b1); wait_idle();
      buf_write(8'h96, 1'b0, 1'b1); wait_idle();
      check("R9", {15'd0, ctl_rdata[6]}, 16'd0);
      divisor = 8'd7;
      cur_req = "R4";  ctl_write(8'h04, 2, 8'h00, 1'b1); wait_idle();

      cur_req = "R13"; ctl_write(8'h40, -1, 8'h00, 1'b1);
      repeat (3) @(negedge clk);
      check("R13", {8'd0, ctl_rdata}, 16'h0000);
      check("R10", {15'd0, done_irq}, 16'd0);

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule